// File: doc/BRIEF.md
# Triangular Loop Index Sequencer

This block drives the control side of a lower-triangular matrix computation such as a Cholesky factorisation, with one iteration issued per clock cycle. It walks columns in the outer loop and rows in the inner loop. For each iteration it gives the downstream datapath the row and column indices, a diagonal flag, a store-enable flag, a flag that says whether the matrix input is to be read, a per-term enable mask for the dot product, and the address of the element in packed lower-triangle storage.

A result written in one iteration may be needed a few iterations later. The datapath needs a fixed number of iterations, `LAT`, before that result can be read back. Once the remaining rows of a column are fewer than that latency, the sequencer does not stall. It starts the row scan of the next column earlier, at `min(column, N-LAT)`, which inserts dummy iterations that store nothing. The trip count therefore follows from `N` and `LAT` alone, and the sequence takes no handshake: one start pulse launches a whole run, and a done pulse marks its final iteration.

Top module: `tri_loop_seq`

## Requirements
- R1: After reset, every output is 0 until a run is launched.
- R2: When `start_i` is high on a clock edge while the block is idle, iteration 0 (row 0, column 0) is presented on the outputs after the next clock edge. Each following iteration is presented one cycle after the one before it, with `valid_o` high throughout the run.
- R3: Row and column both begin at 0. While the row is below N-1, the row increments and the column holds. When the row equals N-1, the column increments and the row restarts at min(new column, N-LAT).
- R4: A run contains exactly N(N+1)/2 + (LAT-1)LAT/2 iterations, minus (LAT-N)(LAT-N+1)/2 when N < LAT.
- R5: `diag_o` is 1 exactly when row equals column.
- R6: `store_o` is 1 exactly when column <= row. Across a run, each lower-triangle element is stored exactly once.
- R7: `rd_o` (matrix input read) is 1 exactly when 0 <= row <= N-1. When it is 0, the datapath uses zero in place of the input.
- R8: Bit k of `term_o` is 1 exactly when k < column. The datapath treats a disabled term as contributing zero.
- R9: When `store_o` is 1, `addr_o` equals row*(row+1)/2 + column. When `store_o` is 0, `addr_o` is 0.
- R10: `done_o` is high for one cycle, together with the final iteration, which is always row N-1, column N-1. `valid_o` is 0 in the cycle after `done_o`.
- R11: `start_i` is ignored while a run is in progress. A new start is accepted in the cycle after `done_o`.
- R12: When N < LAT, the restart row is negative. Rows below zero occur only as dummy iterations, with `store_o`, `rd_o` and `diag_o` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse, used only while idle |
| valid_o | output | 1 | An iteration is presented this cycle |
| row_o | output | RW (signed) | Row index; negative only for dummies |
| col_o | output | CW | Column index |
| diag_o | output | 1 | Row equals column |
| store_o | output | 1 | Result of this iteration is to be written |
| rd_o | output | 1 | Matrix input is to be read for this row |
| term_o | output | N | Dot-product term enables |
| addr_o | output | AW | Packed lower-triangle address |
| done_o | output | 1 | Final iteration of the run |

## Verification
A start sampled on edge P1 puts iteration 0 on the outputs after edge P2, and iteration i after edge P(2+i). Every flag, index and address is registered alongside the indices, so all of them share that latency. The bench raises `start_i` just after a falling edge and samples all outputs at later falling edges. It compares each iteration with a reference walk of the row and column rule, then checks that `done_o` falls on index total-1 and that `valid_o` is low at index total. Three parameter sets are covered: LAT below N, LAT equal to 1, and LAT above N (which gives negative restart rows). A start pulse in the middle of a run checks that the trip count is unchanged.

// File: rtl/tls_pkg.sv
package tls_pkg;

  function automatic int tri_total(input int n, input int lat);
    int base, pad, trim;
    base = n * (n + 1) / 2;
    pad  = (lat - 1) * lat / 2;
    trim = (n >= lat) ? 0 : (lat - n) * (lat - n + 1) / 2;
    return base + pad - trim;
  endfunction

  function automatic int clog2_min1(input int v);
    int w;
    w = $clog2(v);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/tls_counter.sv
module tls_counter
  import tls_pkg::*;
#(
  parameter int N   = 8,
  parameter int LAT = 4,
  parameter int RW  = 4,
  parameter int CW  = 3,
  parameter int TW  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  output logic                 busy,
  output logic                 last,
  output logic signed [RW-1:0] row,
  output logic        [CW-1:0] col
);

  localparam int TOTAL   = tri_total(N, LAT);
  localparam int RESTART = N - LAT;
  localparam int FLOOR   = (RESTART < 0) ? RESTART : 0;

  logic [TW-1:0] cnt;
  int            restart_row;

  always_comb begin
    int c1;
    c1 = int'(col) + 1;
    restart_row = (c1 < RESTART) ? c1 : RESTART;
  end

  assign last = busy && (cnt == TW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      row  <= '0;
      col  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        row  <= '0;
        col  <= '0;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + TW'(1);
      if (int'(row) == N - 1) begin
        col <= col + CW'(1);
        row <= RW'(restart_row);
      end else begin
        row <= row + RW'(1);
      end
    end
  end

  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && row == '0 && col == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && int'(row) != N - 1)
      |=> (int'(row) == $past(int'(row)) + 1 && col == $past(col)));

  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && int'(row) == N - 1)
      |=> (col == $past(col) + CW'(1) && int'(row) <= int'(col)));

  a_r10_corner: assert property (@(posedge clk) disable iff (rst)
    last |-> (int'(row) == N - 1 && int'(col) == N - 1));

  a_r12_floor: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(row) >= FLOOR && int'(row) <= N - 1));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && start) |=> busy);

endmodule

// File: rtl/tls_decode.sv
module tls_decode #(
  parameter int N  = 8,
  parameter int RW = 4,
  parameter int CW = 3,
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 busy,
  input  logic                 last,
  input  logic signed [RW-1:0] row,
  input  logic        [CW-1:0] col,
  output logic                 valid_q,
  output logic                 done_q,
  output logic signed [RW-1:0] row_q,
  output logic        [CW-1:0] col_q,
  output logic                 diag_q,
  output logic                 store_q,
  output logic                 rd_q,
  output logic        [N-1:0]  term_q,
  output logic        [AW-1:0] addr_q
);

  logic          store_d;
  logic [N-1:0]  term_d;
  logic [AW-1:0] addr_d;

  assign store_d = busy && (int'(col) <= int'(row));

  always_comb begin
    int a;
    a = int'(row) * (int'(row) + 1) / 2 + int'(col);
    addr_d = store_d ? AW'(a) : '0;
  end

  for (genvar k = 0; k < N; k++) begin : g_term
    assign term_d[k] = busy && (k < int'(col));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      diag_q  <= 1'b0;
      store_q <= 1'b0;
      rd_q    <= 1'b0;
      term_q  <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= busy;
      done_q  <= last;
      row_q   <= busy ? row : '0;
      col_q   <= busy ? col : '0;
      diag_q  <= busy && (int'(row) == int'(col));
      store_q <= store_d;
      rd_q    <= busy && (int'(row) >= 0) && (int'(row) < N);
      term_q  <= term_d;
      addr_q  <= addr_d;
    end
  end

  a_r10_done_valid: assert property (@(posedge clk) disable iff (rst)
    done_q |-> valid_q);

  a_r10_done_ends: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !valid_q);

  a_r2_burst: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !done_q) |=> valid_q);

  a_r12_dummy_quiet: assert property (@(posedge clk) disable iff (rst)
    (valid_q && row_q[RW-1]) |-> (!store_q && !rd_q && !diag_q));

endmodule

// File: rtl/tri_loop_seq.sv
module tri_loop_seq
  import tls_pkg::*;
#(
  parameter int N   = 8,
  parameter int LAT = 4,
  parameter int RW  = clog2_min1((N > LAT) ? N : LAT) + 1,
  parameter int CW  = clog2_min1(N),
  parameter int AW  = clog2_min1(N * (N + 1) / 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  output logic                 valid_o,
  output logic signed [RW-1:0] row_o,
  output logic        [CW-1:0] col_o,
  output logic                 diag_o,
  output logic                 store_o,
  output logic                 rd_o,
  output logic        [N-1:0]  term_o,
  output logic        [AW-1:0] addr_o,
  output logic                 done_o
);

  localparam int TOTAL = tri_total(N, LAT);
  localparam int TW    = clog2_min1(TOTAL + 1);

  logic                 busy;
  logic                 last;
  logic signed [RW-1:0] row;
  logic        [CW-1:0] col;

  tls_counter #(.N(N), .LAT(LAT), .RW(RW), .CW(CW), .TW(TW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .busy  (busy),
    .last  (last),
    .row   (row),
    .col   (col)
  );

  tls_decode #(.N(N), .RW(RW), .CW(CW), .AW(AW)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .last    (last),
    .row     (row),
    .col     (col),
    .valid_q (valid_o),
    .done_q  (done_o),
    .row_q   (row_o),
    .col_q   (col_o),
    .diag_q  (diag_o),
    .store_q (store_o),
    .rd_q    (rd_o),
    .term_q  (term_o),
    .addr_q  (addr_o)
  );

  initial begin
    if (N < 1 || LAT < 1) $error("N and LAT must be at least 1");
  end

endmodule

// File: tb/sim_tri_loop_seq.sv
`timescale 1ns/1ps
module sim_tri_loop_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic start0 = 1'b0, start1 = 1'b0, start2 = 1'b0;

  logic                v0, d0, dg0, st0, rd0;
  logic signed [3:0]   r0;
  logic        [2:0]   c0;
  logic        [7:0]   t0;
  logic        [5:0]   a0;

  logic                v1, d1, dg1, st1, rd1;
  logic signed [3:0]   r1;
  logic        [1:0]   c1;
  logic        [3:0]   t1;
  logic        [3:0]   a1;

  logic                v2, d2, dg2, st2, rd2;
  logic signed [3:0]   r2;
  logic        [2:0]   c2;
  logic        [4:0]   t2;
  logic        [3:0]   a2;

  tri_loop_seq #(.N(8), .LAT(4)) u0 (
    .clk(clk), .rst(rst), .start_i(start0), .valid_o(v0), .row_o(r0),
    .col_o(c0), .diag_o(dg0), .store_o(st0), .rd_o(rd0), .term_o(t0),
    .addr_o(a0), .done_o(d0));

  tri_loop_seq #(.N(4), .LAT(6)) u1 (
    .clk(clk), .rst(rst), .start_i(start1), .valid_o(v1), .row_o(r1),
    .col_o(c1), .diag_o(dg1), .store_o(st1), .rd_o(rd1), .term_o(t1),
    .addr_o(a1), .done_o(d1));

  tri_loop_seq #(.N(5), .LAT(1)) u2 (
    .clk(clk), .rst(rst), .start_i(start2), .valid_o(v2), .row_o(r2),
    .col_o(c2), .diag_o(dg2), .store_o(st2), .rd_o(rd2), .term_o(t2),
    .addr_o(a2), .done_o(d2));

  int s_valid, s_done, s_diag, s_store, s_rd, s_row, s_col, s_term, s_addr;

  task automatic sample(input int sel);
    case (sel)
      0: begin s_valid = v0; s_done = d0; s_diag = dg0; s_store = st0; s_rd = rd0;
               s_row = int'(r0); s_col = int'(c0); s_term = int'(t0); s_addr = int'(a0); end
      1: begin s_valid = v1; s_done = d1; s_diag = dg1; s_store = st1; s_rd = rd1;
               s_row = int'(r1); s_col = int'(c1); s_term = int'(t1); s_addr = int'(a1); end
      default: begin s_valid = v2; s_done = d2; s_diag = dg2; s_store = st2; s_rd = rd2;
               s_row = int'(r2); s_col = int'(c2); s_term = int'(t2); s_addr = int'(a2); end
    endcase
  endtask

  task automatic set_start(input int sel, input logic v);
    case (sel)
      0: start0 = v;
      1: start1 = v;
      default: start2 = v;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_total(input int n, input int lat);
    int t;
    t = n * (n + 1) / 2 + (lat - 1) * lat / 2;
    if (n < lat) t = t - (lat - n) * (lat - n + 1) / 2;
    return t;
  endfunction

  // Launch a run and check every iteration against the reference walk
  task automatic run_seq(input int sel, input int n, input int lat, input int poke_at);
    int total, r, c, stores, exp_mask, exp_addr, mism;
    bit [63:0] seen;
    total = ref_total(n, lat);
    r = 0; c = 0; stores = 0; mism = 0; seen = '0;
    @(negedge clk); set_start(sel, 1'b1);
    @(negedge clk); set_start(sel, 1'b0);
    @(negedge clk);
    for (int i = 0; i < total; i++) begin
      sample(sel);
      if (i == poke_at) set_start(sel, 1'b1);
      if (i == poke_at + 1) set_start(sel, 1'b0);
      exp_mask = 0;
      for (int k = 0; k < n; k++) if (k < c) exp_mask |= (1 << k);
      exp_addr = (c <= r) ? r * (r + 1) / 2 + c : 0;
      if (s_valid != 1)                     begin mism++; check(0, "R2 valid", s_valid, 1); end
      if (s_row != r || s_col != c)         begin mism++; check(0, "R3 row", s_row, r); check(0, "R3 col", s_col, c); end
      if (s_diag != int'(r == c))           begin mism++; check(0, "R5 diag", s_diag, int'(r == c)); end
      if (s_store != int'(c <= r))          begin mism++; check(0, "R6 store", s_store, int'(c <= r)); end
      if (s_rd != int'(r >= 0 && r < n))    begin mism++; check(0, "R7 rd", s_rd, int'(r >= 0 && r < n)); end
      if (s_term != exp_mask)               begin mism++; check(0, "R8 term", s_term, exp_mask); end
      if (s_addr != exp_addr)               begin mism++; check(0, "R9 addr", s_addr, exp_addr); end
      if (r < 0 && (s_store != 0 || s_rd != 0)) begin mism++; check(0, "R12 dummy", s_store, 0); end
      if (s_done != int'(i == total - 1))   begin mism++; check(0, "R10 done", s_done, int'(i == total - 1)); end
      if (s_store == 1) begin
        if (seen[s_addr]) begin mism++; check(0, "R6 twice", s_addr, -1); end
        seen[s_addr] = 1'b1;
        stores++;
      end
      if (r == n - 1) begin
        c = c + 1;
        r = (c < n - lat) ? c : n - lat;
      end else r = r + 1;
      @(negedge clk);
    end
    check(mism == 0, "R3 sequence", mism, 0);
    check(stores == n * (n + 1) / 2, "R6 store count", stores, n * (n + 1) / 2);
    sample(sel);
    check(s_valid == 0, "R4 run length", s_valid, 0);
    check(s_done == 0, "R10 single pulse", s_done, 0);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk); sample(sel);
      check(s_valid == 0, "R11 no relaunch", s_valid, 0);
    end
  endtask

  task automatic test_reset();
    sample(0); check(s_valid == 0 && s_done == 0 && s_store == 0, "R1 u0 flags", s_valid, 0);
    check(s_row == 0 && s_col == 0 && s_addr == 0 && s_term == 0, "R1 u0 idx", s_row, 0);
    sample(1); check(s_valid == 0 && s_rd == 0 && s_diag == 0, "R1 u1 flags", s_valid, 0);
    sample(2); check(s_valid == 0 && s_term == 0, "R1 u2 flags", s_valid, 0);
  endtask

  // R11: a start right after done is accepted
  task automatic test_back_to_back();
    int cnt;
    cnt = 0;
    @(negedge clk); start2 = 1'b1;
    @(negedge clk); start2 = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); sample(2);
      if (s_done == 1) begin start2 = 1'b1; break; end
    end
    @(negedge clk); start2 = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      sample(2);
      if (s_valid == 1) cnt++;
      @(negedge clk);
    end
    check(cnt == ref_total(5, 1), "R11 relaunch", cnt, ref_total(5, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_seq(0, 8, 4, 10);
    run_seq(1, 4, 6, -5);
    run_seq(2, 5, 1, 3);
    run_seq(0, 8, 4, -5);
    test_back_to_back();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule